// File: doc/BRIEF.md
# Glitch-Free Bypass Output Selector

This block chooses what drives one channel's 1-bit output on every bit clock. There are three possible sources: the requantized stream coming from the channel's noise shaper, an alternating silence pattern, or one of the four raw input streams passed through unchanged. The block inspects the channel's four mixing coefficients to decide which configuration is active. A configuration with all coefficients at zero selects silence. A configuration that routes exactly one input at exactly unity gain is a candidate for bit-exact pass-through. Any other configuration keeps the processed stream.

A switch straight from the shaper's output to the raw input would break the bit sequence at the splice. To avoid this, after an edit into a unity single-input configuration the block keeps sending the processed stream. It also counts how many bit clocks in a row that stream has reproduced the selected input. Once that count reaches the settling length, the output moves to the raw input. Because the two streams are identical at that moment, the switch-over causes no discontinuity. Two mute inputs override every other choice and force silence.

Top module: `bypass_selector`

## Requirements
- R1: While reset is asserted the output is 0.
- R2: In the processed states (ST_PROC, ST_SETTLE), the output equals the processed bit sampled at the previous rising edge. Output latency is one register.
- R3: When all four coefficients are zero and no mute is active, the output follows a silence pattern that inverts on every clock (1010...).
- R4: Coefficient lane i sits in coef_i bits [24i+23:24i] and scales input bit in_bits_i[i]. Unity is exactly 24'h400000. A unity single-input configuration has one lane equal to unity and the other three lanes equal to zero.
- R5: After an edit into a unity single-input configuration, the output stays on the processed bit until the processed bit has equalled the selected input on 32 consecutive edges, not counting the edit edge. The edge that sees the 32nd match enters ST_PASS.
- R6: A single mismatch during settling restarts the consecutive-match count from zero.
- R7: Any change of the coefficient word returns the output to the processed path (or to silence) on the edge that sees the change, and settling starts again from zero.
- R8: A single input at a gain other than exactly unity (half gain, or negative unity 24'hC00000), or more than one nonzero lane, never leads to pass-through.
- R9: Either mute input forces the silence pattern. Mute has priority over pass-through, processing and the coefficient setting.
- R10: Release of mute is treated as an edit, so a unity configuration must settle again before pass-through.
- R11: In ST_PASS the output equals the selected input bit sampled at the previous edge, whatever the processed bit does.

States: ST_PROC (processed stream), ST_SILENT (silence for all-zero coefficients), ST_SETTLE (processed stream while matches are counted), ST_PASS (raw input), ST_MUTE (silence on mute).

Transitions:
- Any state goes to ST_MUTE while a mute is high.
- An edit (a coefficient change, the first clock after reset, or mute release) goes to ST_SILENT, ST_SETTLE or ST_PROC according to the new coefficients.
- ST_SETTLE goes to ST_PASS on the 32nd consecutive match.
- Otherwise the state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_i | input | 96 | Four 24-bit gain coefficients, lane i in bits [24i+23:24i] |
| in_bits_i | input | 4 | Raw 1-bit input streams, bit i belongs to lane i |
| proc_bit_i | input | 1 | Requantizer output bit for this channel |
| mute_ext_i | input | 1 | External mute request |
| mute_int_i | input | 1 | Internal mute request |
| out_bit_o | output | 1 | Selected 1-bit output |

## Verification
A stuck or early match counter shows up as the output following the raw input while the bench drives a processed bit that disagrees with it. An early count is visible on the clock right after the 31st match. A count that is never cleared shows up on the first mismatch after a restart. A state register that misses an edit keeps forwarding the old input on the clock after the coefficient change, and a lost mute leaves the output steady instead of inverting. Every such fault therefore reaches out_bit_o within one clock of the stimulus that should have exposed it.

// File: rtl/bsel_pkg.sv
package bsel_pkg;

    typedef enum logic [2:0] {
        ST_PROC   = 3'd0,
        ST_SILENT = 3'd1,
        ST_SETTLE = 3'd2,
        ST_PASS   = 3'd3,
        ST_MUTE   = 3'd4
    } bsel_state_e;

endpackage

// File: rtl/bsel_coef_classifier.sv
// Classifies one channel's coefficient set: all zero, or a single lane at
// exactly unity with every other lane at zero.
module bsel_coef_classifier #(
    parameter int unsigned NUM_IN = 4,
    parameter int unsigned COEF_W = 24,
    parameter int unsigned SEL_W  = 2,
    parameter logic [COEF_W-1:0] UNITY = 24'h400000
) (
    input  logic [NUM_IN*COEF_W-1:0] coef_i,
    output logic                     all_zero_o,
    output logic                     one_unity_o,
    output logic [SEL_W-1:0]         sel_idx_o
);

    logic [NUM_IN-1:0] lane_zero;
    logic [NUM_IN-1:0] lane_unity;

    for (genvar g = 0; g < NUM_IN; g++) begin : g_lane
        assign lane_zero[g]  = (coef_i[g*COEF_W +: COEF_W] == '0);
        assign lane_unity[g] = (coef_i[g*COEF_W +: COEF_W] == UNITY);
    end

    always_comb begin
        sel_idx_o = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (lane_unity[i]) begin
                sel_idx_o = SEL_W'(i);
            end
        end
    end

    assign all_zero_o  = &lane_zero;
    assign one_unity_o = $onehot(lane_unity) && (&(lane_zero | lane_unity));

endmodule

// File: rtl/bsel_edit_detector.sv
// Flags an edit whenever the coefficient word differs from the one seen on
// the previous edge, and on the first edge after reset.
module bsel_edit_detector #(
    parameter int unsigned WIDTH = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] coef_i,
    output logic             edit_o
);

    logic [WIDTH-1:0] prev_q;
    logic             primed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= coef_i;
            primed_q <= 1'b1;
        end
    end

    assign edit_o = !primed_q || (coef_i != prev_q);

endmodule

// File: rtl/bsel_match_counter.sv
// Counts consecutive edges on which the processed bit reproduced the
// selected input. settled_o marks the edge that completes the run.
module bsel_match_counter #(
    parameter int unsigned SETTLE_LEN = 32,
    localparam int unsigned CNT_W     = $clog2(SETTLE_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic enable_i,
    input  logic match_i,
    output logic settled_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_LEN - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (enable_i) begin
            if (!match_i) begin
                cnt_q <= '0;
            end else if (cnt_q != LAST) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign settled_o = enable_i && match_i && (cnt_q == LAST);

endmodule

// File: rtl/bsel_silence_gen.sv
// Free-running alternating pattern that carries no audio-band energy.
module bsel_silence_gen (
    input  logic clk,
    input  logic rst_n,
    output logic bit_o
);

    logic tog_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else begin
            tog_q <= ~tog_q;
        end
    end

    assign bit_o = tog_q;

endmodule

// File: rtl/bypass_selector.sv
// Output selector for one channel: processed stream, silence, or a
// bit-exact input once the processed stream has converged onto it.
module bypass_selector
    import bsel_pkg::*;
#(
    parameter int unsigned NUM_IN     = 4,
    parameter int unsigned COEF_W     = 24,
    parameter int unsigned FRAC_W     = 22,
    parameter int unsigned SETTLE_LEN = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_IN*COEF_W-1:0] coef_i,
    input  logic [NUM_IN-1:0]        in_bits_i,
    input  logic                     proc_bit_i,
    input  logic                     mute_ext_i,
    input  logic                     mute_int_i,
    output logic                     out_bit_o
);

    localparam int unsigned SEL_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
    localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << FRAC_W;

    bsel_state_e state_q;
    bsel_state_e state_d;

    logic             all_zero;
    logic             one_unity;
    logic [SEL_W-1:0] sel_idx;
    logic             coef_edit;
    logic             reeval;
    logic             mute;
    logic             sel_bit;
    logic             match;
    logic             settled;
    logic             silence_bit;
    logic             out_d;
    logic             out_q;

    bsel_coef_classifier #(
        .NUM_IN (NUM_IN),
        .COEF_W (COEF_W),
        .SEL_W  (SEL_W),
        .UNITY  (UNITY)
    ) u_classify (
        .coef_i      (coef_i),
        .all_zero_o  (all_zero),
        .one_unity_o (one_unity),
        .sel_idx_o   (sel_idx)
    );

    bsel_edit_detector #(
        .WIDTH (NUM_IN*COEF_W)
    ) u_edit (
        .clk    (clk),
        .rst_n  (rst_n),
        .coef_i (coef_i),
        .edit_o (coef_edit)
    );

    assign mute    = mute_ext_i | mute_int_i;
    assign reeval  = coef_edit || (state_q == ST_MUTE);
    assign sel_bit = in_bits_i[sel_idx];
    assign match   = (proc_bit_i == sel_bit);

    bsel_match_counter #(
        .SETTLE_LEN (SETTLE_LEN)
    ) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (reeval || mute),
        .enable_i  ((state_q == ST_SETTLE) && !reeval && !mute),
        .match_i   (match),
        .settled_o (settled)
    );

    bsel_silence_gen u_silence (
        .clk   (clk),
        .rst_n (rst_n),
        .bit_o (silence_bit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PROC;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (mute) begin
            state_d = ST_MUTE;
        end else if (reeval) begin
            if (all_zero) begin
                state_d = ST_SILENT;
            end else if (one_unity) begin
                state_d = ST_SETTLE;
            end else begin
                state_d = ST_PROC;
            end
        end else begin
            unique case (state_q)
                ST_PROC:   state_d = ST_PROC;
                ST_SILENT: state_d = ST_SILENT;
                ST_SETTLE: state_d = settled ? ST_PASS : ST_SETTLE;
                ST_PASS:   state_d = ST_PASS;
                ST_MUTE:   state_d = ST_MUTE;
                default:   state_d = ST_PROC;
            endcase
        end
    end

    // Output selection follows the state being entered
    always_comb begin
        unique case (state_d)
            ST_PROC,
            ST_SETTLE: out_d = proc_bit_i;
            ST_PASS:   out_d = sel_bit;
            ST_SILENT,
            ST_MUTE:   out_d = silence_bit;
            default:   out_d = proc_bit_i;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_bit_o = out_q;

endmodule

// File: rtl/bypass_selector_chk.sv
module bypass_selector_chk
    import bsel_pkg::*;
#(
    parameter int unsigned NUM_IN = 4,
    parameter int unsigned COEF_W = 24,
    parameter int unsigned SEL_W  = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_IN*COEF_W-1:0] coef_i,
    input logic [NUM_IN-1:0]        in_bits_i,
    input logic                     proc_bit_i,
    input logic                     mute_ext_i,
    input logic                     mute_int_i,
    input logic                     out_bit_o,
    input bsel_state_e              state,
    input logic                     all_zero,
    input logic                     one_unity,
    input logic [SEL_W-1:0]         sel_idx
);

    logic live_q;
    logic mute_c;
    logic sel_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    assign mute_c = mute_ext_i | mute_int_i;
    assign sel_c  = in_bits_i[sel_idx];

    // R1
    always_comb begin
        if (!rst_n) begin
            a_r1_reset_low: assert (out_bit_o == 1'b0);
        end
    end

    a_r2_proc_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && (state == ST_PROC || state == ST_SETTLE)) |-> out_bit_o == $past(proc_bit_i));

    a_r3_zero_silence: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && all_zero && !mute_c) ##1 (all_zero && !mute_c) |=> out_bit_o != $past(out_bit_o));

    a_r5_pass_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && state == ST_PASS && $past(state) != ST_PASS)
            |-> ($past(state) == ST_SETTLE && $past(proc_bit_i == sel_c)));

    a_r7_change_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && coef_i != $past(coef_i)) |=> state != ST_PASS);

    a_r8_pass_needs_unity: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && state == ST_PASS) |-> $past(one_unity));

    a_r9_mute_silence: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && mute_c) ##1 mute_c |=> out_bit_o != $past(out_bit_o));

    a_r11_pass_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && state == ST_PASS) |-> out_bit_o == $past(sel_c));

endmodule

bind bypass_selector bypass_selector_chk #(
    .NUM_IN (NUM_IN),
    .COEF_W (COEF_W),
    .SEL_W  (SEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .coef_i     (coef_i),
    .in_bits_i  (in_bits_i),
    .proc_bit_i (proc_bit_i),
    .mute_ext_i (mute_ext_i),
    .mute_int_i (mute_int_i),
    .out_bit_o  (out_bit_o),
    .state      (state_q),
    .all_zero   (all_zero),
    .one_unity  (one_unity),
    .sel_idx    (sel_idx)
);

// File: tb/bypass_selector_tb.sv
`timescale 1ns/1ps
module bypass_selector_tb;

    localparam logic [23:0] UNITY = 24'h400000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] coef = '0;
    logic [3:0]  inb = '0;
    logic        proc = 1'b0;
    logic        mute_ext = 1'b0;
    logic        mute_int = 1'b0;
    logic        out_bit;

    int checks = 0;
    int fails  = 0;
    logic [15:0] lf = 16'hACE1;

    always #2 clk = ~clk;

    bypass_selector u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .coef_i     (coef),
        .in_bits_i  (inb),
        .proc_bit_i (proc),
        .mute_ext_i (mute_ext),
        .mute_int_i (mute_int),
        .out_bit_o  (out_bit)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: out=%0b expected %0b", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [3:0] rnd4();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return lf[3:0];
    endfunction

    function automatic logic [95:0] one_lane(input int lane, input logic [23:0] val);
        logic [95:0] c = '0;
        c[lane*24 +: 24] = val;
        return c;
    endfunction

    // drive inputs where processed bit matches (or not) the lane's input
    task automatic step(input int lane, input logic same);
        inb  = rnd4();
        proc = same ? inb[lane] : ~inb[lane];
        tick();
    endtask

    task automatic run_matches(input int lane, input int n);
        for (int i = 0; i < n; i++) step(lane, 1'b1);
    endtask

    // zero tick, then edit into coefficient word c with a matching edit edge
    task automatic edit_to(input logic [95:0] c, input int lane);
        coef = '0;
        tick();
        coef = c;
        step(lane, 1'b1);
    endtask

    task automatic t_processed();
        coef = {24'h0, 24'h200000, 24'h0, 24'h100000};
        for (int i = 0; i < 8; i++) begin
            inb  = rnd4();
            proc = lf[7];
            tick();
            chk("R2 processed bit forwarded", out_bit, proc);
        end
    endtask

    task automatic t_silence();
        logic prev;
        coef = '0;
        proc = 1'b1;
        inb  = 4'hF;
        tick();
        prev = out_bit;
        for (int i = 0; i < 5; i++) begin
            tick();
            chk("R3 zero coefficients alternate", out_bit, ~prev);
            prev = out_bit;
        end
    endtask

    task automatic t_bypass(input int lane);
        edit_to(one_lane(lane, UNITY), lane);
        chk("R5 edit edge stays processed", out_bit, proc);
        run_matches(lane, 32);
        step(lane, 1'b0);
        chk("R4 R5 bypass after 32 matches", out_bit, inb[lane]);
        for (int i = 0; i < 3; i++) begin
            step(lane, 1'b0);
            chk("R11 pass ignores processed bit", out_bit, inb[lane]);
        end
    endtask

    task automatic t_short_run();
        edit_to(one_lane(1, UNITY), 1);
        run_matches(1, 31);
        step(1, 1'b0);
        chk("R5 31 matches not enough", out_bit, proc);
        run_matches(1, 31);
        step(1, 1'b0);
        chk("R6 mismatch restarts count", out_bit, proc);
        run_matches(1, 32);
        step(1, 1'b0);
        chk("R6 full run after restart", out_bit, inb[1]);
    endtask

    task automatic t_change();
        t_bypass(0);
        coef = one_lane(3, UNITY);
        step(3, 1'b0);
        chk("R7 change drops to processed", out_bit, proc);
        run_matches(3, 32);
        step(3, 1'b0);
        chk("R7 re-settle on new lane", out_bit, inb[3]);
        coef = '0;
        proc = 1'b1;
        tick();
        begin
            logic first = out_bit;
            tick();
            chk("R7 change to zero gives silence", out_bit, ~first);
        end
    endtask

    task automatic t_non_unity();
        edit_to(one_lane(2, 24'h200000), 2);
        run_matches(2, 40);
        step(2, 1'b0);
        chk("R8 half gain never bypasses", out_bit, proc);
        edit_to(one_lane(2, 24'hC00000), 2);
        run_matches(2, 40);
        step(2, 1'b0);
        chk("R8 negative unity never bypasses", out_bit, proc);
        edit_to(one_lane(2, UNITY) | one_lane(0, UNITY), 2);
        run_matches(2, 40);
        step(2, 1'b0);
        chk("R8 two unity lanes never bypass", out_bit, proc);
    endtask

    task automatic t_mute(input bit use_ext);
        logic prev;
        t_bypass(2);
        if (use_ext) mute_ext = 1'b1; else mute_int = 1'b1;
        proc = 1'b1;
        inb  = 4'hF;
        tick();
        prev = out_bit;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk(use_ext ? "R9 external mute silences" : "R9 internal mute silences",
                out_bit, ~prev);
            prev = out_bit;
        end
        mute_ext = 1'b0;
        mute_int = 1'b0;
        step(2, 1'b0);
        chk("R10 release restarts settling", out_bit, proc);
        run_matches(2, 32);
        step(2, 1'b0);
        chk("R10 bypass after re-settle", out_bit, inb[2]);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset output", out_bit, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_processed();
        t_silence();
        t_bypass(0);
        t_bypass(3);
        t_short_run();
        t_change();
        t_non_unity();
        t_mute(1'b1);
        t_mute(1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: out=%0b expected finish", out_bit);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule